// File: doc/BRIEF.md
# Watchdog Timer with Shared Prescaler

This block is a watchdog timer that runs from a slow internal clock of about 31 kHz. The clock first passes through a divider whose power-of-two tap is picked by a period code. It then passes through an 8-bit prescaler. The 8-bit prescaler has two possible owners: the watchdog, or a general-purpose timer that sits outside this block. A select input decides which one uses it. When the watchdog count runs out, the block raises a single-cycle time-out pulse and starts counting again from zero.

Two inputs can turn the watchdog on. A non-volatile configuration input forces it on. When that input is low, a software enable bit in a small control register decides instead. Several events restart the count:
- a clear command;
- an oscillator-fail event;
- disabling the watchdog;
- a wake from sleep.

After a wake from sleep with a crystal clock, the count stays cleared until the oscillator start-up timer reports that it has finished. While the start-up timer is running, it holds the count at zero.

Top module: `wdog_core`

## Requirements
- R1: After reset the control register reads 5'b01000. Bits 4..1 hold the period code, which resets to 4. Bit 0 holds the software enable, which resets to 0. No time-out occurs while the watchdog stays disabled.
- R2: While `cfgForceEn` is 1, the watchdog counts whatever the software enable bit holds. Writing 0 to that bit does not stop the time-outs.
- R3: While `cfgForceEn` is 0, a software enable of 1 runs the watchdog. A software enable of 0 stops it and holds the count at zero, so no time-out occurs.
- R4: A period code n sets the first-stage ratio R to 2^(n+5). Any code with n+5 >= 16 saturates at R = 65536.
- R5: The factor P depends on `psAssignWdt`. When it is 1, P = 2^(psRatio+1). When it is 0, P = 1. The time-out period is R*P cycles.
- R6: With `psAssignWdt` = 0, `tmrPsTick` pulses once every 2^(psRatio+1) cycles in which `tmrSrcTick` is high. With `psAssignWdt` = 1, every `tmrSrcTick` appears on `tmrPsTick` one cycle later.
- R7: Changing `psAssignWdt` clears the shared prescaler count.
- R8: A `clrCmd` or `oscFail` pulse on clock edge C restarts the count. The next time-out then appears in the cycle after edge C+R*P.
- R9: While `ostActive` is 1, the count is held at zero and no time-out is produced. Counting starts on the first edge after `ostActive` falls.
- R10: On `sleepExit` with `clkIsCrystal` = 0, the count is cleared once. On `sleepExit` with `clkIsCrystal` = 1, the count stays cleared until an `ostDone` pulse arrives.
- R11: `timeout` lasts exactly one cycle. Once the watchdog is running, successive time-outs are exactly R*P cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow oscillator clock (about 31 kHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| ctlWrEn | input | 1 | Write strobe for the control register |
| ctlWrData | input | 5 | Control data: {period code[3:0], software enable} |
| ctrlRdData | output | 5 | Control register readback |
| cfgForceEn | input | 1 | Non-volatile forced enable |
| clrCmd | input | 1 | Clear-watchdog command pulse |
| oscFail | input | 1 | Oscillator-fail detected pulse |
| sleepExit | input | 1 | Wake-from-sleep pulse |
| clkIsCrystal | input | 1 | System clock is a crystal mode |
| ostActive | input | 1 | Oscillator start-up timer is running |
| ostDone | input | 1 | Start-up timer expiry pulse |
| psAssignWdt | input | 1 | 1: shared prescaler to watchdog, 0: to timer |
| psRatio | input | 3 | Shared prescaler ratio select |
| tmrSrcTick | input | 1 | Timer clock-source tick |
| tmrPsTick | output | 1 | Prescaled tick to the timer |
| timeout | output | 1 | Watchdog time-out pulse |

## Verification
The first time-out is counted from the first edge on which the count advances.
- After a forced-enable rise or an `ostActive` fall driven before edge d+1, the first time-out is due at cycle d+R*P.
- After a register write, clear, sleep exit or `ostDone` pulse driven before edge d+1, it is due at d+1+R*P.
- Every later time-out is due R*P cycles after the previous one.
- A prescaled timer tick appears on the edge that completes its count.

The driver task queues the exact cycle numbers at which time-outs are due. A monitor samples at falling edges. It fails any time-out that arrives at a cycle not in the queue, and any queued cycle that passes without a time-out. Events are driven well away from queued cycles, so no result depends on which process runs first at the same edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic cntEn;    // advance the first stage
    logic cntClr;   // restart the watchdog count
    logic psClr;    // reassignment: clear the shared prescaler
    logic psToWdt;  // shared prescaler owned by the watchdog
  } wdogStrb_t;

endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int CODE_W   = 4,
  parameter int RST_CODE = 4,
  localparam int CTRL_W  = CODE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctlWrEn,
  input  logic [CTRL_W-1:0] ctlWrData,
  input  logic              cfgForceEn,
  input  logic              clrCmd,
  input  logic              oscFail,
  input  logic              sleepExit,
  input  logic              clkIsCrystal,
  input  logic              ostActive,
  input  logic              ostDone,
  input  logic              psAssignWdt,
  output logic [CTRL_W-1:0] ctrlReg,
  output wdogStrb_t         strb
);

  localparam logic [CTRL_W-1:0] CTRL_RST = {CODE_W'(RST_CODE), 1'b0};

  logic xtalWait;
  logic prevAssign;
  logic wdtOn;
  logic holdClr;

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrlReg <= CTRL_RST;
    else if (ctlWrEn) ctrlReg <= ctlWrData;
  end

  // Crystal wake: keep the count cleared until the start-up timer expires
  always_ff @(posedge clk) begin
    if (!rst_n)                          xtalWait <= 1'b0;
    else if (sleepExit && clkIsCrystal)  xtalWait <= 1'b1;
    else if (ostDone)                    xtalWait <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prevAssign <= 1'b0;
    else        prevAssign <= psAssignWdt;
  end

  always_comb begin
    wdtOn        = cfgForceEn | ctrlReg[0];
    holdClr      = ostActive | xtalWait;
    strb.cntEn   = wdtOn & ~holdClr;
    strb.cntClr  = ~wdtOn | holdClr | clrCmd | oscFail | sleepExit;
    strb.psClr   = psAssignWdt ^ prevAssign;
    strb.psToWdt = psAssignWdt;
  end

endmodule

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int CODE_W  = 4,
  parameter int S1_W    = 16,
  parameter int S1_BASE = 5,
  parameter int PS_W    = 8,
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  wdogStrb_t          strb,
  input  logic [CODE_W-1:0]  periodCode,
  input  logic [RATIO_W-1:0] psRatio,
  input  logic               tmrSrcTick,
  output logic               tmrPsTick,
  output logic               timeout
);

  localparam int SH_W = 8;

  logic [SH_W-1:0] shAmt;
  logic [S1_W-1:0] s1Mask;
  logic [S1_W-1:0] s1Cnt;
  logic [PS_W-1:0] psMask;
  logic [PS_W-1:0] psCnt;
  logic            s1Tick;
  logic            psHit;
  logic            wdtTick;

  // First-stage tap, saturating at the full counter width
  always_comb begin
    shAmt = SH_W'(periodCode) + SH_W'(S1_BASE);
    if (shAmt >= SH_W'(S1_W)) s1Mask = '1;
    else                      s1Mask = S1_W'((32'd1 << shAmt) - 32'd1);
    psMask  = PS_W'((32'd1 << (32'(psRatio) + 32'd1)) - 32'd1);
    s1Tick  = strb.cntEn && (s1Cnt >= s1Mask);
    psHit   = (psCnt >= psMask);
    wdtTick = strb.psToWdt ? (s1Tick && psHit) : s1Tick;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      s1Cnt <= '0;
    else if (strb.cntClr || s1Tick)  s1Cnt <= '0;
    else if (strb.cntEn)             s1Cnt <= s1Cnt + 1'b1;
  end

  // Shared prescaler: counts first-stage ticks or timer ticks
  always_ff @(posedge clk) begin
    if (!rst_n)            psCnt <= '0;
    else if (strb.psClr)   psCnt <= '0;
    else if (strb.psToWdt) begin
      if (strb.cntClr || wdtTick) psCnt <= '0;
      else if (s1Tick)            psCnt <= psCnt + 1'b1;
    end else if (tmrSrcTick) begin
      psCnt <= psHit ? '0 : psCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timeout   <= 1'b0;
      tmrPsTick <= 1'b0;
    end else begin
      timeout   <= wdtTick && !strb.cntClr;
      tmrPsTick <= strb.psToWdt ? tmrSrcTick
                                : (tmrSrcTick && psHit && !strb.psClr);
    end
  end

  // R11
  timeout_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout);

  // R7
  ps_reassign_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.psClr |=> (psCnt == '0));

  // R8
  timeout_needs_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> $past(strb.cntEn));

endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int CODE_W   = 4,
  parameter int RST_CODE = 4,
  parameter int S1_W     = 16,
  parameter int S1_BASE  = 5,
  parameter int PS_W     = 8,
  parameter int RATIO_W  = 3,
  localparam int CTRL_W  = CODE_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctlWrEn,
  input  logic [CTRL_W-1:0]  ctlWrData,
  output logic [CTRL_W-1:0]  ctrlRdData,
  input  logic               cfgForceEn,
  input  logic               clrCmd,
  input  logic               oscFail,
  input  logic               sleepExit,
  input  logic               clkIsCrystal,
  input  logic               ostActive,
  input  logic               ostDone,
  input  logic               psAssignWdt,
  input  logic [RATIO_W-1:0] psRatio,
  input  logic               tmrSrcTick,
  output logic               tmrPsTick,
  output logic               timeout
);

  wdogStrb_t         strb;
  logic [CTRL_W-1:0] ctrlReg;

  wdog_ctrl #(.CODE_W(CODE_W), .RST_CODE(RST_CODE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .cfgForceEn(cfgForceEn), .clrCmd(clrCmd), .oscFail(oscFail),
    .sleepExit(sleepExit), .clkIsCrystal(clkIsCrystal),
    .ostActive(ostActive), .ostDone(ostDone), .psAssignWdt(psAssignWdt),
    .ctrlReg(ctrlReg), .strb(strb)
  );

  wdog_dp #(.CODE_W(CODE_W), .S1_W(S1_W), .S1_BASE(S1_BASE),
            .PS_W(PS_W), .RATIO_W(RATIO_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .periodCode(ctrlReg[CTRL_W-1:1]), .psRatio(psRatio),
    .tmrSrcTick(tmrSrcTick), .tmrPsTick(tmrPsTick), .timeout(timeout)
  );

  assign ctrlRdData = ctrlReg;

  // R3
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfgForceEn && !ctrlReg[0]) |=> !timeout);

  // R9
  ost_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ostActive |=> !timeout);

endmodule

// File: tb/wdog_core_test.sv
`timescale 1ns/1ps
module wdog_core_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctlWrEn;
  logic [4:0] ctlWrData;
  logic [4:0] ctrlRdData;
  logic       cfgForceEn, clrCmd, oscFail, sleepExit, clkIsCrystal;
  logic       ostActive, ostDone, psAssignWdt, tmrSrcTick;
  logic [2:0] psRatio;
  logic       tmrPsTick, timeout;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int    expQ[$];
  string tagQ[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_core uut (
    .clk(clk), .rst_n(rst_n), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .ctrlRdData(ctrlRdData), .cfgForceEn(cfgForceEn), .clrCmd(clrCmd),
    .oscFail(oscFail), .sleepExit(sleepExit), .clkIsCrystal(clkIsCrystal),
    .ostActive(ostActive), .ostDone(ostDone), .psAssignWdt(psAssignWdt),
    .psRatio(psRatio), .tmrSrcTick(tmrSrcTick), .tmrPsTick(tmrPsTick),
    .timeout(timeout)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Driver side of the scoreboard: queue due cycles of time-outs
  task automatic pushExp(input int first, input int step, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      expQ.push_back(first + i * step);
      tagQ.push_back(tag);
    end
  endtask

  task automatic dropExp();
    expQ.delete();
    tagQ.delete();
  endtask

  task automatic wr(input logic [4:0] v);
    ctlWrData = v;
    ctlWrEn   = 1'b1;
    @(negedge clk);
    ctlWrEn   = 1'b0;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor side of the scoreboard
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      while (expQ.size() > 0 && cyc > expQ[0]) begin
        checks++; fails++;
        $display("FAIL %s: time-out missing, actual none expected cycle %0d", tagQ[0], expQ[0]);
        void'(expQ.pop_front());
        void'(tagQ.pop_front());
      end
      if (timeout) begin
        checks++;
        if (expQ.size() > 0 && expQ[0] == cyc) begin
          void'(expQ.pop_front());
          void'(tagQ.pop_front());
        end else begin
          fails++;
          $display("FAIL R11: unexpected time-out, actual cycle %0d expected %0d",
                   cyc, (expQ.size() > 0) ? expQ[0] : -1);
        end
      end
    end
  end

  initial begin
    #(4 * 190000);
    fails++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int d, cnt, first;
    rst_n = 1'b0; ctlWrEn = 0; ctlWrData = '0; cfgForceEn = 0; clrCmd = 0;
    oscFail = 0; sleepExit = 0; clkIsCrystal = 0; ostActive = 0; ostDone = 0;
    psAssignWdt = 0; psRatio = '0; tmrSrcTick = 0;
    waitN(5);
    rst_n = 1'b1;

    // R1: reset value and quiet while disabled
    chk(ctrlRdData == 5'b01000, "R1 reset control value", ctrlRdData, 5'b01000);
    chk(timeout == 1'b0, "R1 reset time-out low", timeout, 0);
    waitN(1000);
    chk(expQ.size() == 0, "R1 quiet while disabled", expQ.size(), 0);

    // R2: forced enable, reset period code 4 -> 512 cycles
    d = cyc; cfgForceEn = 1'b1;
    pushExp(d + 512, 512, 4, "R2/R4 forced run period");
    waitN(1124);
    wr(5'b01000);                          // software enable 0: ignored (R2)
    waitN(500);

    // R8: clear command
    dropExp();
    d = cyc; clrCmd = 1'b1; waitN(1); clrCmd = 1'b0;
    pushExp(d + 1 + 512, 512, 3, "R8 clear command restart");
    waitN(812);

    // R8: oscillator fail
    dropExp();
    d = cyc; oscFail = 1'b1; waitN(1); oscFail = 1'b0;
    pushExp(d + 1 + 512, 512, 3, "R8 oscillator fail restart");
    waitN(700);

    // R9: start-up timer hold
    dropExp();
    ostActive = 1'b1;
    waitN(1500);
    d = cyc; ostActive = 1'b0;
    pushExp(d + 512, 512, 2, "R9 resume after start-up hold");
    waitN(600);

    // R10: sleep exit on a non-crystal clock
    dropExp();
    d = cyc; sleepExit = 1'b1; clkIsCrystal = 1'b0; waitN(1); sleepExit = 1'b0;
    pushExp(d + 1 + 512, 512, 2, "R10 non-crystal sleep exit");
    waitN(600);

    // R10: sleep exit on a crystal clock, held until start-up expiry
    dropExp();
    sleepExit = 1'b1; clkIsCrystal = 1'b1; waitN(1); sleepExit = 1'b0;
    waitN(1500);
    d = cyc; ostDone = 1'b1; waitN(1); ostDone = 1'b0;
    pushExp(d + 1 + 512, 512, 2, "R10 crystal wait for start-up expiry");
    waitN(600);

    // R3: removing the forced enable with software enable 0 stops it
    dropExp();
    cfgForceEn = 1'b0;
    waitN(1200);
    chk(expQ.size() == 0, "R3 disabled quiet", expQ.size(), 0);

    // R3/R4/R11: software enable, code 0 -> 32 cycles
    d = cyc; wr(5'b00001);
    pushExp(d + 1 + 32, 32, 5, "R3/R4/R11 software run code 0");
    waitN(169);
    wr(5'b00000);
    waitN(300);
    chk(expQ.size() == 0, "R3 software disable", expQ.size(), 0);

    // R5: shared prescaler on the watchdog, ratio 2 -> x8
    psAssignWdt = 1'b1; psRatio = 3'd2;
    waitN(2);
    d = cyc; wr(5'b00001);
    pushExp(d + 1 + 256, 256, 3, "R5 prescaler on watchdog");
    waitN(3 * 256 + 20);
    wr(5'b00000);
    waitN(2);

    // R4: saturating code 13 -> 65536 cycles
    psAssignWdt = 1'b0;
    waitN(2);
    d = cyc; wr(5'b11011);
    pushExp(d + 1 + 65536, 65536, 1, "R4 saturated period");
    waitN(65536 + 20);
    wr(5'b11010);
    waitN(2);
    chk(expQ.size() == 0, "R4 saturated time-out seen", expQ.size(), 0);

    // R6: timer path, ratio 1 -> one tick per 4
    psRatio = 3'd1; tmrSrcTick = 1'b1;
    waitN(8);
    cnt = 0;
    for (int i = 0; i < 400; i++) begin @(negedge clk); cnt += tmrPsTick; end
    chk(cnt == 100, "R6 timer prescaled tick count", cnt, 100);
    psAssignWdt = 1'b1;
    waitN(3);
    cnt = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); cnt += tmrPsTick; end
    chk(cnt == 100, "R6 timer pass-through", cnt, 100);
    tmrSrcTick = 1'b0;

    // R7: reassignment clears a partial prescaler count
    psAssignWdt = 1'b0;
    waitN(2);
    tmrSrcTick = 1'b1; waitN(2); tmrSrcTick = 1'b0;   // count now 2
    cfgForceEn = 1'b1;
    psAssignWdt = 1'b1; waitN(1);
    psAssignWdt = 1'b0; waitN(1);
    cfgForceEn = 1'b0;
    waitN(1);
    d = cyc; tmrSrcTick = 1'b1;
    first = -1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (tmrPsTick && first < 0) first = cyc;
    end
    tmrSrcTick = 1'b0;
    chk(first == d + 4, "R7 reassignment clears count", first, d + 4);

    waitN(5);
    chk(expQ.size() == 0, "R11 all time-outs observed", expQ.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule